// File: doc/BRIEF.md
# Hardwired Instruction Sequencer

This block is the control unit of a small accumulator machine with a 32-word by 8-bit store and a 5-bit program counter. Each 8-bit instruction holds a 3-bit opcode in its upper bits and a 5-bit operand or address in its lower bits. The block is a hardwired sequencer built from three parts. A step counter counts the control steps. A phase flip-flop records whether the machine is fetching or executing. A combinational decoder turns the phase, the step and the opcode into register enables, store read and write strobes, multiplexer selects and a 2-bit ALU function select.

Every instruction begins with a fixed four-step fetch. The store is read synchronously with one cycle of latency, so the data register loads one step after the read is issued. Execution then runs the step pattern that belongs to the opcode. Actions that do not depend on each other share a step. The last step of each phase flips the phase flip-flop and returns the counter to zero. The surrounding datapath supplies the opcode field from its instruction register and the condition flags. It obeys the enables in the same cycle they are asserted.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the unit is in the fetch phase (exec_o=0) with step_o=0001. The only action asserted is mar_ld_o, with mar_src_o=0 (address from the PC).
- R2: In the fetch phase, step_o takes the values 0001, 0010, 0100 and 1000 in order. The actions are: step 0, mar_ld_o with mar_src_o=0; step 1, ms_rd_o; step 2, mdr_ld_o with mdr_src_o=0 (data from the store); step 3, ir_ld_o and pc_inc_o together. No other action is asserted during fetch.
- R3: The cycle after fetch step 3 starts the execute phase (exec_o=1) at step 0. opcode_i and flags_i have no effect on the outputs during fetch.
- R4: Opcodes 000, 001, 010 and 011 (clear, decrement, add immediate, increment) each take one execute step. That step asserts acc_ld_o with acc_src_o=0 (from the ALU), and alu_fs_o is 00, 01, 10 or 11 respectively.
- R5: Opcode 110 (load) takes four execute steps: mar_ld_o with mar_src_o=1 (address from the operand); then ms_rd_o; then mdr_ld_o with mdr_src_o=0; then acc_ld_o with acc_src_o=1 (from the data register).
- R6: Opcode 100 (store) takes two execute steps. The first asserts mar_ld_o with mar_src_o=1 and, in the same step, mdr_ld_o with mdr_src_o=1 (from the accumulator). The second asserts ms_wr_o.
- R7: Opcode 101 (branch on zero) takes one execute step. It asserts pc_ld_o exactly when flags_i[0] (zero flag) is 1. flags_i[1] has no effect.
- R8: Opcode 111 is undefined. It takes one execute cycle with no action asserted, and fetch then restarts.
- R9: The cycle after the last execute step of any opcode is fetch step 0. step_o is always one-hot.
- R10: ms_rd_o and ms_wr_o are never both high, and acc_ld_o is never high in the fetch phase. alu_fs_o is 00 whenever acc_ld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 3 | Opcode field of the instruction register |
| flags_i | input | 2 | Condition flags, bit 0 zero, bit 1 negative |
| exec_o | output | 1 | Phase: 0 fetch, 1 execute |
| step_o | output | 4 | One-hot control step within the phase |
| mar_ld_o | output | 1 | Load the memory address register |
| mar_src_o | output | 1 | Address source: 0 PC, 1 instruction operand |
| ms_rd_o | output | 1 | Store read strobe |
| ms_wr_o | output | 1 | Store write strobe |
| mdr_ld_o | output | 1 | Load the memory data register |
| mdr_src_o | output | 1 | Data register source: 0 store, 1 accumulator |
| ir_ld_o | output | 1 | Load the instruction register |
| pc_inc_o | output | 1 | Increment the program counter |
| pc_ld_o | output | 1 | Load the program counter from the operand |
| acc_ld_o | output | 1 | Load the accumulator |
| acc_src_o | output | 1 | Accumulator source: 0 ALU, 1 data register |
| alu_fs_o | output | 2 | ALU function select |

## Verification
Faults in the step counter or in the phase flip-flop show up at step_o and exec_o in the same cycle. A wrong action decode shows up at the enable outputs in the step where it occurs. A sequence length that is off by one shows up no later than one cycle after the intended last step, because the next cycle is not fetch step 0. Each of the eight opcodes is run under all four flag values, with the opcode and flag inputs inverted during fetch. The outputs are compared every cycle, so any slip in the step count is caught at the first cycle that differs.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
  localparam int unsigned OP_W        = 3;
  localparam int unsigned FLAG_W      = 2;
  localparam int unsigned ALU_OPS     = 4;
  localparam int unsigned FS_W        = $clog2(ALU_OPS);
  localparam int unsigned FETCH_STEPS = 4;
  localparam int unsigned MAX_STEPS   = 4;
  localparam int unsigned STEP_W      = $clog2(MAX_STEPS);

  typedef enum logic [OP_W-1:0] {
    OP_CLR   = 3'b000,
    OP_DEC   = 3'b001,
    OP_ADDI  = 3'b010,
    OP_INC   = 3'b011,
    OP_STORE = 3'b100,
    OP_BRZ   = 3'b101,
    OP_LOAD  = 3'b110,
    OP_UNDEF = 3'b111
  } op_e;

  typedef enum logic [FS_W-1:0] {
    FS_CLR = 2'b00,
    FS_DEC = 2'b01,
    FS_ADD = 2'b10,
    FS_INC = 2'b11
  } fs_e;

  typedef struct packed {
    logic            mar_ld;
    logic            mar_src;
    logic            ms_rd;
    logic            ms_wr;
    logic            mdr_ld;
    logic            mdr_src;
    logic            ir_ld;
    logic            pc_inc;
    logic            pc_ld;
    logic            acc_ld;
    logic            acc_src;
    logic [FS_W-1:0] alu_fs;
  } ctrl_t;

  function automatic int unsigned exec_len(op_e op);
    case (op)
      OP_LOAD:  return 4;
      OP_STORE: return 2;
      default:  return 1;
    endcase
  endfunction
endpackage

// File: rtl/hcu_fe_flop.sv
module hcu_fe_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_i,
  output logic exec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     exec_o <= 1'b0;
    else if (last_i) exec_o <= ~exec_o;
  end
endmodule

// File: rtl/hcu_step_seq.sv
module hcu_step_seq #(
  parameter int unsigned STEPS  = hcu_pkg::MAX_STEPS,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [STEPS-1:0] step_oh_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_i) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  for (genvar i = 0; i < STEPS; i++) begin : g_oh
    assign step_oh_o[i] = (cnt_o == CNT_W'(i));
  end
endmodule

// File: rtl/hcu_decoder.sv
module hcu_decoder
  import hcu_pkg::*;
#(
  parameter logic [FLAG_W-1:0] BR_MASK = 2'b01
) (
  input  logic              exec_i,
  input  logic [STEP_W-1:0] cnt_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FLAG_W-1:0] flags_i,
  output ctrl_t             ctrl_o,
  output logic              last_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    ctrl_o = '0;
    last_o = 1'b0;
    if (!exec_i) begin
      last_o = (cnt_i == STEP_W'(FETCH_STEPS - 1));
      case (cnt_i)
        2'd0: ctrl_o.mar_ld = 1'b1;
        2'd1: ctrl_o.ms_rd  = 1'b1;
        2'd2: ctrl_o.mdr_ld = 1'b1;
        default: begin
          ctrl_o.ir_ld  = 1'b1;
          ctrl_o.pc_inc = 1'b1;     // own incrementer, overlaps IR load
        end
      endcase
    end else begin
      last_o = (cnt_i == STEP_W'(exec_len(op) - 1));
      case (op)
        OP_CLR:  begin ctrl_o.acc_ld = 1'b1; ctrl_o.alu_fs = FS_CLR; end
        OP_DEC:  begin ctrl_o.acc_ld = 1'b1; ctrl_o.alu_fs = FS_DEC; end
        OP_ADDI: begin ctrl_o.acc_ld = 1'b1; ctrl_o.alu_fs = FS_ADD; end
        OP_INC:  begin ctrl_o.acc_ld = 1'b1; ctrl_o.alu_fs = FS_INC; end
        OP_LOAD: begin
          case (cnt_i)
            2'd0: begin ctrl_o.mar_ld = 1'b1; ctrl_o.mar_src = 1'b1; end
            2'd1: ctrl_o.ms_rd = 1'b1;
            2'd2: ctrl_o.mdr_ld = 1'b1;
            default: begin ctrl_o.acc_ld = 1'b1; ctrl_o.acc_src = 1'b1; end
          endcase
        end
        OP_STORE: begin
          if (cnt_i == '0) begin
            // address and data paths are disjoint: one step
            ctrl_o.mar_ld  = 1'b1;
            ctrl_o.mar_src = 1'b1;
            ctrl_o.mdr_ld  = 1'b1;
            ctrl_o.mdr_src = 1'b1;
          end else begin
            ctrl_o.ms_wr = 1'b1;
          end
        end
        OP_BRZ:  ctrl_o.pc_ld = |(flags_i & BR_MASK);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import hcu_pkg::*;
#(
  parameter logic [FLAG_W-1:0] BR_MASK = 2'b01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic [FLAG_W-1:0]   flags_i,
  output logic                exec_o,
  output logic [MAX_STEPS-1:0] step_o,
  output logic                mar_ld_o,
  output logic                mar_src_o,
  output logic                ms_rd_o,
  output logic                ms_wr_o,
  output logic                mdr_ld_o,
  output logic                mdr_src_o,
  output logic                ir_ld_o,
  output logic                pc_inc_o,
  output logic                pc_ld_o,
  output logic                acc_ld_o,
  output logic                acc_src_o,
  output logic [FS_W-1:0]     alu_fs_o
);
  logic              last;
  logic              exec_q;
  logic [STEP_W-1:0] cnt;
  ctrl_t             ctrl;

  hcu_fe_flop u_fe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_i (last),
    .exec_o (exec_q)
  );

  hcu_step_seq #(.STEPS(MAX_STEPS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .cnt_o     (cnt),
    .step_oh_o (step_o)
  );

  hcu_decoder #(.BR_MASK(BR_MASK)) u_dec (
    .exec_i  (exec_q),
    .cnt_i   (cnt),
    .op_i    (opcode_i),
    .flags_i (flags_i),
    .ctrl_o  (ctrl),
    .last_o  (last)
  );

  assign exec_o    = exec_q;
  assign mar_ld_o  = ctrl.mar_ld;
  assign mar_src_o = ctrl.mar_src;
  assign ms_rd_o   = ctrl.ms_rd;
  assign ms_wr_o   = ctrl.ms_wr;
  assign mdr_ld_o  = ctrl.mdr_ld;
  assign mdr_src_o = ctrl.mdr_src;
  assign ir_ld_o   = ctrl.ir_ld;
  assign pc_inc_o  = ctrl.pc_inc;
  assign pc_ld_o   = ctrl.pc_ld;
  assign acc_ld_o  = ctrl.acc_ld;
  assign acc_src_o = ctrl.acc_src;
  assign alu_fs_o  = ctrl.alu_fs;

  AST_STEP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(step_o)) else $error("step not one-hot"); // R9
  AST_FETCH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_o && step_o[0]) |-> (mar_ld_o && !mar_src_o)) else $error("fetch start"); // R2
  AST_READ_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mar_ld_o && !mdr_ld_o) |=> ms_rd_o) else $error("read after address"); // R5
  AST_WRITE_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mar_ld_o && mdr_ld_o) |=> ms_wr_o) else $error("write after address"); // R6
  AST_DATA_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_rd_o |=> (mdr_ld_o && !mdr_src_o)) else $error("data after read"); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ms_rd_o && ms_wr_o)) else $error("read and write"); // R10
  AST_ACC_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ld_o |-> exec_o) else $error("acc load in fetch"); // R10
  AST_BRANCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ld_o |-> flags_i[0]) else $error("branch without zero"); // R7
  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> ((exec_o != $past(exec_o)) && step_o[0])) else $error("phase flip"); // R9
endmodule

// File: tb/hw_ctrl_unit_tb.sv
`timescale 1ns/1ps
module hw_ctrl_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] opcode_i = 3'b000;
  logic [1:0] flags_i = 2'b00;
  logic       exec_o, mar_ld_o, mar_src_o, ms_rd_o, ms_wr_o, mdr_ld_o, mdr_src_o;
  logic       ir_ld_o, pc_inc_o, pc_ld_o, acc_ld_o, acc_src_o;
  logic [3:0] step_o;
  logic [1:0] alu_fs_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hw_ctrl_unit u_dut (
    .clk_i, .rst_ni, .opcode_i, .flags_i, .exec_o, .step_o,
    .mar_ld_o, .mar_src_o, .ms_rd_o, .ms_wr_o, .mdr_ld_o, .mdr_src_o,
    .ir_ld_o, .pc_inc_o, .pc_ld_o, .acc_ld_o, .acc_src_o, .alu_fs_o
  );

  function automatic int ilen(logic [2:0] op);
    if (op == 3'b110) return 4;
    if (op == 3'b100) return 2;
    return 1;
  endfunction

  // order: exec, step[3:0], mar_ld, mar_src, ms_rd, ms_wr, mdr_ld, mdr_src,
  //        ir_ld, pc_inc, pc_ld, acc_ld, acc_src, fs[1:0]
  function automatic logic [17:0] expv(bit ex, int s, logic [2:0] op, logic [1:0] fl);
    logic [3:0] st = 4'b0001 << s;
    logic ml = 0, msrc = 0, rd = 0, wr = 0, dl = 0, dsrc = 0;
    logic il = 0, pi = 0, pl = 0, al = 0, asrc = 0;
    logic [1:0] fs = 2'b00;
    if (!ex) begin
      case (s)
        0: ml = 1;
        1: rd = 1;
        2: dl = 1;
        default: begin il = 1; pi = 1; end
      endcase
    end else if (op <= 3'b011) begin
      al = 1; fs = op[1:0];
    end else if (op == 3'b110) begin
      case (s)
        0: begin ml = 1; msrc = 1; end
        1: rd = 1;
        2: dl = 1;
        default: begin al = 1; asrc = 1; end
      endcase
    end else if (op == 3'b100) begin
      if (s == 0) begin ml = 1; msrc = 1; dl = 1; dsrc = 1; end
      else wr = 1;
    end else if (op == 3'b101) begin
      pl = fl[0];
    end
    return {ex, st, ml, msrc, rd, wr, dl, dsrc, il, pi, pl, al, asrc, fs};
  endfunction

  task automatic check(string tag, logic [17:0] e);
    logic [17:0] a;
    a = {exec_o, step_o, mar_ld_o, mar_src_o, ms_rd_o, ms_wr_o, mdr_ld_o, mdr_src_o,
         ir_ld_o, pc_inc_o, pc_ld_o, acc_ld_o, acc_src_o, alu_fs_o};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, a, e);
    end
    // R10 invariants at the ports
    total++;
    if ((ms_rd_o && ms_wr_o) || (acc_ld_o && !exec_o) || (!acc_ld_o && alu_fs_o != 2'b00)) begin
      bad++;
      $display("FAIL R10: rd=%b wr=%b acc=%b ex=%b fs=%b expected exclusive", ms_rd_o,
               ms_wr_o, acc_ld_o, exec_o, alu_fs_o);
    end
  endtask

  function automatic string tag_of(logic [2:0] op);
    if (op <= 3'b011) return "R3 R4";
    if (op == 3'b110) return "R3 R5";
    if (op == 3'b100) return "R3 R6";
    if (op == 3'b101) return "R3 R7";
    return "R3 R8";
  endfunction

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 check("R1 reset", expv(0, 0, 3'b000, 2'b00));
    repeat (3) @(negedge clk_i);
    check("R1 held", expv(0, 0, 3'b000, 2'b00));
    rst_ni = 1'b1;
    #1 check("R1 first cycle", expv(0, 0, 3'b000, 2'b00));
    for (int op = 0; op < 8; op++) begin
      for (int fl = 0; fl < 4; fl++) begin
        for (int s = 0; s < 4; s++) begin
          opcode_i = ~3'(op);
          flags_i  = ~2'(fl);
          #1 check(s == 0 ? "R9 R2" : "R2 R3", expv(0, s, 3'(op), 2'(fl)));
          @(negedge clk_i);
        end
        for (int s = 0; s < ilen(3'(op)); s++) begin
          opcode_i = 3'(op);
          flags_i  = 2'(fl);
          #1 check(tag_of(3'(op)), expv(1, s, 3'(op), 2'(fl)));
          @(negedge clk_i);
        end
      end
    end
    opcode_i = 3'b010;
    #1 check("R9 final", expv(0, 0, 3'b000, 2'b00));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule